// File: doc/BRIEF.md
# Zero-Substitution Bipolar Line Encoder

This block turns a serial bit stream into three-level line symbols, one symbol per accepted bit. The base rule is alternate mark inversion: a zero bit becomes the zero level, and each one bit becomes a pulse whose polarity is opposite to the pulse before it. Long strings of zero bits starve a receiver of timing. To avoid that, the encoder recognises runs of zeros and rewrites them with patterns that contain deliberate polarity violations, which a receiver can recognise and undo.

Two substitution modes exist. In the long mode, a run of eight zeros is rewritten with a pattern holding two violations, each followed by a balancing pulse of opposite sign. In the short mode, a run of four zeros is rewritten with a pattern whose last position is a violation, and whose first position may carry a balancing pulse so that successive violations alternate in sign. The encoder holds the most recent bits in a delay line as deep as the active run length, so a finished run is still inside the line when it is detected and can be rewritten in place. Input uses a valid/ready handshake, and each output symbol is flagged by a symbol-valid strobe.

Top module: `zs_bipolar_encoder`

## Requirements
- R1: Each symbol is two bits: 2'b01 is a positive pulse, 2'b11 is a negative pulse and 2'b00 is the zero level. The code 2'b10 never appears.
- R2: Outside substituted runs, a 0 bit gives the zero level and a 1 bit gives a pulse opposite to the previous pulse. The first 1 bit after reset is positive.
- R3: In long mode (mode_sel=0), each completed run of 8 zeros is sent as 0 0 0 V B 0 V B. The first V has the polarity of the last pulse before the run, each B is opposite to the V before it, and the alternation reference after the pattern equals the one before it.
- R4: In short mode (mode_sel=1), each completed run of 4 zeros is sent as 0 0 0 V if an odd number of pulses was sent since the last violation, and as B 0 0 V if that number is even. Here V repeats the polarity of the last pulse. B is a normal alternating pulse and resets that count, and the count starts even after reset.
- R5: In short mode, consecutive violations alternate in polarity.
- R6: The output never contains as many consecutive zero symbols as the active run length.
- R7: Latency is the active run length in accepted bits. sym_valid pulses in the cycle after an accept, but only once that many bits are held. A stream of N+L bits therefore yields exactly N symbols, the first N in order.
- R8: During reset, in_ready and sym_valid are low. After reset, in_ready is high, sym_valid is low and sym is 2'b00.
- R9: mode_sel is taken only in a cycle with in_valid low and no zero run pending. The mode is long from reset until the first such cycle. A change made while a run is partly counted has no effect on that run.
- R10: The zero-run count is cleared by a 1 bit and after each substitution. A run one shorter than the run length passes through unchanged.
- R11: Idle cycles between accepted bits do not change the symbol sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_sel | input | 1 | 0: eight-zero substitution, 1: four-zero substitution |
| in_valid | input | 1 | Input bit offered |
| in_bit | input | 1 | Data bit |
| in_ready | output | 1 | Encoder accepts a bit this cycle |
| sym_valid | output | 1 | sym holds a new symbol this cycle |
| sym | output | 2 | Line symbol (01 positive, 11 negative, 00 zero) |

## Verification
The assertions check the following on every cycle:
- only legal symbol codes appear;
- every strobe follows an accept;
- no zero run on the output reaches the run length;
- in short mode, successive violations differ in sign;
- in long mode, every violation is followed at once by an opposite pulse;
- the active mode moves only on an idle cycle with no run pending;
- a substitution fires only on an accepted zero.

Only the bench's scenarios can show the following:
- the exact pattern chosen from the odd/even pulse count;
- the polarity taken from the pulse before a run;
- the exact output latency;
- that idle gaps and a mode change made mid-run leave the symbol stream unchanged.

// File: rtl/zs_pkg.sv
package zs_pkg;

  typedef enum logic [1:0] {
    SYM_ZERO = 2'b00,
    SYM_POS  = 2'b01,
    SYM_NEG  = 2'b11
  } sym_t;

  // Pulse of a given sign: neg=1 gives a negative pulse.
  function automatic logic [1:0] pulse_of(input logic neg);
    return neg ? SYM_NEG : SYM_POS;
  endfunction

  // Symbol for an ordinary bit, given the sign of the last pulse sent.
  function automatic logic [1:0] mark_symbol(input logic bit_v, input logic last_neg);
    if (!bit_v) return SYM_ZERO;
    return pulse_of(!last_neg);
  endfunction

  // True when s repeats the sign of the previous pulse.
  function automatic logic is_violation(input logic [1:0] s, input logic [1:0] prev_pulse);
    return (s != SYM_ZERO) && (prev_pulse != SYM_ZERO) && (s == prev_pulse);
  endfunction

  // Larger of two run lengths.
  function automatic int max_len(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/zs_run_tracker.sv
module zs_run_tracker
  import zs_pkg::*;
#(
  parameter int RUN_LONG  = 8,
  parameter int RUN_SHORT = 4,
  parameter int LW        = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          accept,
  input  logic          bit_i,
  input  logic          mode_sel,
  output logic          mode_short,
  output logic [LW-1:0] run_len,
  output logic [LW-1:0] run_cnt,
  output logic          subst
);

  localparam logic [LW-1:0] LEN_L = LW'(RUN_LONG);
  localparam logic [LW-1:0] LEN_S = LW'(RUN_SHORT);

  logic          mode_q;
  logic [LW-1:0] cnt_q;
  logic          mode_load;
  logic          run_done;

  assign run_len   = mode_q ? LEN_S : LEN_L;
  assign run_done  = (cnt_q == run_len - LW'(1));
  assign subst     = accept && !bit_i && run_done;
  assign mode_load = !in_valid && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
    end else if (mode_load) begin
      mode_q <= mode_sel;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (accept) begin
      if (bit_i || run_done) begin
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + LW'(1);
      end
    end
  end

  assign mode_short = mode_q;
  assign run_cnt    = cnt_q;

endmodule

// File: rtl/zs_polarity.sv
module zs_polarity
  import zs_pkg::*;
#(
  parameter int RUN_LONG  = 8,
  parameter int RUN_SHORT = 4,
  parameter int MAXD      = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 accept,
  input  logic                 bit_i,
  input  logic                 subst,
  input  logic                 mode_short,
  output logic [1:0]           cur_sym,
  output logic [MAXD-1:0][1:0] pat
);

  // Slot 0 holds the newest bit; a run of L zeros fills slots L-1..0.
  localparam int SLOT_V1 = 4;
  localparam int SLOT_B1 = 3;
  localparam int SLOT_V2 = 1;
  localparam int SLOT_B2 = 0;
  localparam int SLOT_SB = RUN_SHORT - 1;

  logic       last_neg_q;
  logic       odd_q;
  logic [1:0] same_p;
  logic [1:0] oppo_p;

  assign same_p  = pulse_of(last_neg_q);
  assign oppo_p  = pulse_of(!last_neg_q);
  assign cur_sym = mark_symbol(bit_i, last_neg_q);

  always_comb begin
    for (int i = 0; i < MAXD; i++) pat[i] = SYM_ZERO;
    if (!mode_short) begin
      pat[SLOT_V1] = same_p;
      pat[SLOT_B1] = oppo_p;
      pat[SLOT_V2] = oppo_p;
      pat[SLOT_B2] = same_p;
    end else if (odd_q) begin
      pat[0] = same_p;
    end else begin
      pat[SLOT_SB] = oppo_p;
      pat[0]       = oppo_p;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_neg_q <= 1'b1;
      odd_q      <= 1'b0;
    end else if (accept) begin
      if (subst) begin
        if (mode_short) begin
          odd_q <= 1'b0;
          if (!odd_q) last_neg_q <= !last_neg_q;
        end
      end else if (bit_i) begin
        last_neg_q <= !last_neg_q;
        odd_q      <= !odd_q;
      end
    end
  end

endmodule

// File: rtl/zs_delay_line.sv
module zs_delay_line
  import zs_pkg::*;
#(
  parameter int MAXD = 8,
  parameter int LW   = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 accept,
  input  logic [LW-1:0]        run_len,
  input  logic [1:0]           new_sym,
  input  logic                 subst,
  input  logic [MAXD-1:0][1:0] pat,
  output logic [1:0]           sym_o,
  output logic                 sym_valid_o
);

  logic [MAXD-1:0][1:0] line_q;
  logic [MAXD-1:0][1:0] line_d;
  logic [LW-1:0]        fill_q;
  logic [1:0]           tap_sym;
  logic                 full;

  for (genvar g = 0; g < MAXD; g++) begin : g_slot
    logic [1:0] shifted;
    if (g == 0) begin : g_head
      assign shifted = new_sym;
    end else begin : g_body
      assign shifted = line_q[g-1];
    end
    assign line_d[g] = (subst && (LW'(g) < run_len)) ? pat[g] : shifted;
  end

  always_comb begin
    tap_sym = SYM_ZERO;
    for (int i = 0; i < MAXD; i++) begin
      if (LW'(i) == run_len - LW'(1)) tap_sym = line_q[i];
    end
  end

  assign full = (fill_q >= run_len);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q      <= '0;
      fill_q      <= '0;
      sym_o       <= SYM_ZERO;
      sym_valid_o <= 1'b0;
    end else begin
      sym_valid_o <= accept && full;
      if (accept) begin
        line_q <= line_d;
        if (full) sym_o <= tap_sym;
        if (fill_q < LW'(MAXD)) fill_q <= fill_q + LW'(1);
      end
    end
  end

endmodule

// File: rtl/zs_bipolar_encoder.sv
module zs_bipolar_encoder
  import zs_pkg::*;
#(
  parameter int RUN_LONG  = 8,
  parameter int RUN_SHORT = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode_sel,
  input  logic       in_valid,
  input  logic       in_bit,
  output logic       in_ready,
  output logic       sym_valid,
  output logic [1:0] sym
);

  localparam int MAXD = max_len(RUN_LONG, RUN_SHORT);
  localparam int LW   = $clog2(MAXD + 1);

  logic                 ready_q;
  logic                 accept;
  logic                 mode_short;
  logic [LW-1:0]        run_len;
  logic [LW-1:0]        run_cnt;
  logic                 subst_fire;
  logic [1:0]           cur_sym;
  logic [MAXD-1:0][1:0] pat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= 1'b1;
  end

  assign in_ready = ready_q;
  assign accept   = in_valid && ready_q;

  zs_run_tracker #(
    .RUN_LONG (RUN_LONG),
    .RUN_SHORT(RUN_SHORT),
    .LW       (LW)
  ) u_run (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .accept    (accept),
    .bit_i     (in_bit),
    .mode_sel  (mode_sel),
    .mode_short(mode_short),
    .run_len   (run_len),
    .run_cnt   (run_cnt),
    .subst     (subst_fire)
  );

  zs_polarity #(
    .RUN_LONG (RUN_LONG),
    .RUN_SHORT(RUN_SHORT),
    .MAXD     (MAXD)
  ) u_pol (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .bit_i     (in_bit),
    .subst     (subst_fire),
    .mode_short(mode_short),
    .cur_sym   (cur_sym),
    .pat       (pat)
  );

  zs_delay_line #(
    .MAXD(MAXD),
    .LW  (LW)
  ) u_line (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (accept),
    .run_len    (run_len),
    .new_sym    (cur_sym),
    .subst      (subst_fire),
    .pat        (pat),
    .sym_o      (sym),
    .sym_valid_o(sym_valid)
  );

endmodule

// File: rtl/zs_encoder_checker.sv
module zs_encoder_checker
  import zs_pkg::*;
#(
  parameter int RUN_LONG  = 8,
  parameter int RUN_SHORT = 4,
  parameter int LW        = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          in_bit,
  input logic          sym_valid,
  input logic [1:0]    sym,
  input logic          mode_now,
  input logic [LW-1:0] run_cnt,
  input logic          subst_fire
);

  logic [LW-1:0] zr_q;
  logic [LW-1:0] lim;
  logic [1:0]    prev_q;
  logic [1:0]    lastv_q;
  logic          has_v_q;
  logic          pend_b_q;
  logic          viol;

  assign lim  = mode_now ? LW'(RUN_SHORT) : LW'(RUN_LONG);
  assign viol = sym_valid && is_violation(sym, prev_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      zr_q     <= '0;
      prev_q   <= SYM_ZERO;
      lastv_q  <= SYM_ZERO;
      has_v_q  <= 1'b0;
      pend_b_q <= 1'b0;
    end else if (sym_valid) begin
      if (sym == SYM_ZERO) begin
        if (zr_q != '1) zr_q <= zr_q + LW'(1);
      end else begin
        zr_q   <= '0;
        prev_q <= sym;
      end
      if (viol) begin
        lastv_q <= sym;
        has_v_q <= 1'b1;
      end
      pend_b_q <= viol;
    end
  end

  AST_SYM_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    sym != 2'b10); // R1

  AST_VALID_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    sym_valid |-> $past(in_valid && in_ready)); // R7

  AST_ZERO_RUN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_valid && sym == SYM_ZERO) |-> (zr_q < lim - LW'(1))); // R6

  AST_SHORT_VIOL_ALT: assert property (@(posedge clk) disable iff (!rst_n)
    (viol && mode_now && has_v_q) |-> (sym != lastv_q)); // R5

  AST_LONG_BALANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_valid && pend_b_q && !mode_now) |-> (sym != SYM_ZERO && sym != prev_q)); // R3

  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(!in_valid && run_cnt == '0) |=> $stable(mode_now)); // R9

  AST_SUBST_ON_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    subst_fire |-> (in_valid && in_ready && !in_bit)); // R10

endmodule

bind zs_bipolar_encoder zs_encoder_checker #(
  .RUN_LONG (RUN_LONG),
  .RUN_SHORT(RUN_SHORT),
  .LW       (LW)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_bit    (in_bit),
  .sym_valid (sym_valid),
  .sym       (sym),
  .mode_now  (mode_short),
  .run_cnt   (run_cnt),
  .subst_fire(subst_fire)
);

// File: tb/zs_bipolar_encoder_test.sv
module zs_bipolar_encoder_test;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 7;

  typedef struct packed {
    logic         mode;
    logic [15:0]  tag;
    logic [127:0] bits;
    logic [127:0] exp;
  } vec_t;

  // Symbols as characters: '+' = 2'b01, '-' = 2'b11, '0' = 2'b00 (R1)
  localparam vec_t VECS [0:NV-1] = '{
    '{mode: 1'b0, tag: "R3", bits: "1100000000110000", exp: "+-000-+0+-+-0000"},
    '{mode: 1'b1, tag: "R4", bits: "1100000000110000", exp: "+-+00+-00-+-+00+"},
    '{mode: 1'b1, tag: "R4", bits: "1000010000000000", exp: "+000+-000-+00+00"},
    '{mode: 1'b0, tag: "R10", bits: "1000000010000000", exp: "+0000000-0000000"},
    '{mode: 1'b0, tag: "R3", bits: "1000000000000000", exp: "+000+-0-+0000000"},
    '{mode: 1'b0, tag: "R3", bits: "0000000011110000", exp: "000-+0+-+-+-0000"},
    '{mode: 1'b1, tag: "R4", bits: "0000000000001111", exp: "+00+-00-+00+-+-+"}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_sel = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_bit = 1'b0;
  logic       in_ready;
  logic       sym_valid;
  logic [1:0] sym;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int got_n = 0;
  logic [1:0] got [0:63];

  zs_bipolar_encoder uut (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_sel (mode_sel),
    .in_valid (in_valid),
    .in_bit   (in_bit),
    .in_ready (in_ready),
    .sym_valid(sym_valid),
    .sym      (sym)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (rst_n && sym_valid && got_n < 64) begin
      got[got_n] = sym;
      got_n = got_n + 1;
    end
  end

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (cyc > 100000) begin
      fails = fails + 1;
      $display("FAIL watchdog R7: got %0d cycles, expected at most 100000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks + 1, fails);
      $finish;
    end
  end

  function automatic logic [1:0] sym_of_char(input logic [7:0] c);
    if (c == "+") return 2'b01;
    if (c == "-") return 2'b11;
    return 2'b00;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int actual, input int expect_v);
    checks = checks + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s %s: got %0d expected %0d", req, what, actual, expect_v);
    end
  endtask

  task automatic do_reset(input logic m);
    @(negedge clk);
    rst_n = 1'b0;
    in_valid = 1'b0;
    mode_sel = m;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    got_n = 0;
  endtask

  task automatic feed(input logic b, input bit gap);
    if (gap) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
    @(negedge clk);
    in_valid = 1'b1;
    in_bit = b;
  endtask

  task automatic finish_stream();
    @(negedge clk);
    in_valid = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic run_vector(input int k, input bit gap, input string req);
    vec_t v;
    int   len;
    int   zr;
    int   zmax;
    logic [1:0] prev;
    logic [1:0] lastv;
    bit   alt_ok;
    v = VECS[k];
    len = v.mode ? 4 : 8;
    do_reset(v.mode);
    for (int i = 0; i < 16; i++) feed(v.bits[8*(15-i) +: 8] == "1", gap);
    for (int i = 0; i < len; i++) feed(1'b1, gap);
    finish_stream();
    chk(got_n == 16 + len - len, "R7", $sformatf("vec %0d symbol count", k), got_n, 16);
    for (int i = 0; i < 16; i++) begin
      logic [1:0] e;
      e = sym_of_char(v.exp[8*(15-i) +: 8]);
      chk(got[i] == e, {req, "/R1"}, $sformatf("vec %0d symbol %0d", k, i),
          int'(got[i]), int'(e));
    end
    zr = 0;
    zmax = 0;
    prev = 2'b00;
    lastv = 2'b00;
    alt_ok = 1'b1;
    for (int i = 0; i < got_n; i++) begin
      if (got[i] == 2'b00) begin
        zr = zr + 1;
        if (zr > zmax) zmax = zr;
      end else begin
        zr = 0;
        if (prev != 2'b00 && got[i] == prev) begin
          if (lastv != 2'b00 && got[i] == lastv) alt_ok = 1'b0;
          lastv = got[i];
        end
        prev = got[i];
      end
    end
    chk(zmax < len, "R6", $sformatf("vec %0d longest zero run", k), zmax, len - 1);
    if (v.mode) chk(alt_ok, "R5", $sformatf("vec %0d violation alternation", k), int'(alt_ok), 1);
  endtask

  initial begin
    // R8: reset state
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(in_ready == 1'b0, "R8", "in_ready during reset", int'(in_ready), 0);
    chk(sym_valid == 1'b0, "R8", "sym_valid during reset", int'(sym_valid), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(in_ready == 1'b1, "R8", "in_ready after reset", int'(in_ready), 1);
    chk(sym_valid == 1'b0, "R8", "sym_valid after reset", int'(sym_valid), 0);
    chk(sym == 2'b00, "R8", "sym after reset", int'(sym), 0);

    for (int k = 0; k < NV; k++) run_vector(k, 1'b0, string'(VECS[k].tag));

    // R11: idle gaps between bits leave the stream unchanged
    run_vector(1, 1'b1, "R11");
    run_vector(4, 1'b1, "R11");

    // R7 / R2: latency in short mode, first mark positive
    do_reset(1'b1);
    for (int i = 0; i < 4; i++) feed(1'b1, 1'b0);
    @(negedge clk);
    in_valid = 1'b0;
    chk(got_n == 0, "R7", "symbols before buffer full", got_n, 0);
    feed(1'b1, 1'b0);
    finish_stream();
    chk(got_n == 1, "R7", "symbols after fifth bit", got_n, 1);
    chk(got[0] == 2'b01, "R2", "first mark after reset", int'(got[0]), 1);

    // R9: mode change during a partly counted run is not applied
    do_reset(1'b0);
    feed(1'b1, 1'b0);
    for (int i = 0; i < 4; i++) feed(1'b0, 1'b0);
    @(negedge clk);
    in_valid = 1'b0;
    mode_sel = 1'b1;
    repeat (3) @(negedge clk);
    for (int i = 0; i < 4; i++) feed(1'b0, 1'b0);
    for (int i = 0; i < 8; i++) feed(1'b1, 1'b0);
    finish_stream();
    chk(got_n == 9, "R9", "symbol count with held mode", got_n, 9);
    begin
      logic [71:0] hold_exp;
      hold_exp = "+000+-0-+";
      for (int i = 0; i < 9; i++) begin
        logic [1:0] e;
        e = sym_of_char(hold_exp[8*(8-i) +: 8]);
        chk(got[i] == e, "R9", $sformatf("held-mode symbol %0d", i), int'(got[i]), int'(e));
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule